// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Front End

This block is the host-visible register front end of one bus-master disk DMA channel. It holds a command byte, a status byte and a 32-bit descriptor-table base address. It decodes byte-granular host accesses of one, two or four bytes at a byte offset inside each register. It turns changes of the command start bit into start and stop requests for a separate DMA engine. That engine moves the data and walks the descriptor table. This block keeps only the table pointer the engine begins from.

The engine reports back through three inputs: a busy level while a transfer is outstanding, a completion pulse and an error pulse. A stop requested by the host during an outstanding transfer is deferred until the transfer drains, so a partial transfer never reaches the medium. The device interrupt passes straight to the output line, and its rising level is also latched into a status bit that the host clears by writing 1.

Top module: `busmaster_dma_regs`

## Requirements
- R1: Register select encoding is 0 = command, 1 = status, 2 = base address, 3 = unused (reads 0, writes ignored). Command and status writes take effect only at byte offset 0. A command write stores only bit 0 (start) and bit 3 (direction, driven on `dirOut`), and the command register reads back with every other bit zero.
- R2: A command write whose start bit equals the stored start bit raises neither `startReq` nor `stopReq` and leaves `curTablePtr` unchanged. The direction bit is still updated.
- R3: A command write that moves start from 0 to 1 loads `curTablePtr` from the base address at that clock edge. If the active bit (status bit 0) was clear, the same edge sets it and `startReq` is high for exactly one cycle. If the active bit was already set, no `startReq` is raised.
- R4: A command write that moves start from 1 to 0 while the channel is active and `engXferBusy` is high keeps the active bit set. At the first edge that sees `engXferBusy` low, the active bit clears and `stopReq` pulses for one cycle. With `engXferBusy` low at the write, this happens at the write edge. A start 0-to-1 write before that edge cancels the pending stop.
- R5: A base address write updates only the byte lanes from the offset up to offset plus access width minus 1. Lane offset+k takes byte k of `hostWrData`. Bits 1:0 of the stored address are always zero.
- R6: Size code 0 selects 1 byte, 1 selects 2 bytes, and 2 or 3 selects 4 bytes. A read returns the selected register shifted right by 8 times the offset, masked to the access width.
- R7: `irqOut` equals `devIrqIn` in the same cycle. A high `devIrqIn` sets status bit 2 at the next edge. A low `devIrqIn` leaves status bit 2 unchanged.
- R8: Writing 1 to status bit 2 or bit 1 clears that bit, and writing 0 leaves it. A set condition in the same cycle wins. Host writes never change status bit 0. An `engErr` pulse sets status bit 1.
- R9: An `engDone` pulse clears the active bit at the next edge.
- R10: Reset clears the command, status, base address and `curTablePtr`, and holds `startReq` and `stopReq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hostWe | input | 1 | Host write strobe |
| hostSel | input | 2 | Register select |
| hostOff | input | 2 | Byte offset within the register |
| hostSize | input | 2 | Access width code |
| hostWrData | input | 32 | Write data, byte 0 in bits 7:0 |
| hostRdData | output | 32 | Read data (combinational) |
| engXferBusy | input | 1 | Engine has a transfer outstanding |
| engDone | input | 1 | Engine completion pulse |
| engErr | input | 1 | Engine error pulse |
| devIrqIn | input | 1 | Device interrupt level |
| irqOut | output | 1 | Interrupt line to the host |
| startReq | output | 1 | One-cycle kick to the engine |
| stopReq | output | 1 | One-cycle stop notice to the engine |
| dirOut | output | 1 | Transfer direction from the command register |
| activeOut | output | 1 | Status active bit |
| curTablePtr | output | 32 | Descriptor table pointer for the engine |

## Verification
The bench rewrites the start bit with its current value. A design that acts on the level of the start bit instead of its change would kick the engine twice or reload the pointer. It drops the start bit while the engine is busy and checks that the active bit holds until busy falls. It then re-enables start during such a pending stop, which must cancel the stop without a second kick. Partial-lane address writes with junk in the upper data bytes catch a wrong lane mask or a missing clear of bits 1:0. The interrupt checks hold the device line high across a write-1-to-clear, where a design with the wrong priority would lose the interrupt.

// File: rtl/bmregs_pkg.sv
package bmregs_pkg;

  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_STAT = 2'd1,
    SEL_BASE = 2'd2,
    SEL_NONE = 2'd3
  } regSel_e;

  // decoded host write strobes
  typedef struct packed {
    logic cmdWr;
    logic statWr;
    logic baseWr;
  } hostDec_t;

  // control to datapath strobes
  typedef struct packed {
    logic loadPtr;
  } ctrlStrobe_t;

endpackage

// File: rtl/bm_datapath.sv
module bm_datapath
  import bmregs_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NBYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(NBYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  hostDec_t          dec,
  input  ctrlStrobe_t       strb,
  input  regSel_e           sel,
  input  logic [OFF_W-1:0]  off,
  input  logic [1:0]        sizeCode,
  input  logic [DATA_W-1:0] wrData,
  input  logic              devIrqIn,
  input  logic              engErr,
  input  logic              cmdStart,
  input  logic              cmdDir,
  input  logic              active,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] tablePtr,
  output logic              irqFlag
);

  logic [DATA_W-1:0] baseAddr, baseNext, shiftedWr, regVal, shiftedRd;
  logic              errFlag;
  int unsigned       nBytes;
  int unsigned       offInt;

  always_comb begin
    offInt = 32'(off);
    case (sizeCode)
      2'd0:    nBytes = 1;
      2'd1:    nBytes = (NBYTES < 2) ? NBYTES : 2;
      default: nBytes = NBYTES;
    endcase
  end

  // lane-masked base address update, low two bits forced clear
  always_comb begin
    shiftedWr = wrData << (8 * offInt);
    baseNext  = baseAddr;
    for (int i = 0; i < NBYTES; i++) begin
      if (i >= offInt && i < offInt + nBytes)
        baseNext[8*i +: 8] = shiftedWr[8*i +: 8];
    end
    baseNext[1:0] = 2'b00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      baseAddr <= '0;
      tablePtr <= '0;
      irqFlag  <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      if (dec.baseWr) baseAddr <= baseNext;
      if (strb.loadPtr) tablePtr <= baseAddr;
      irqFlag <= devIrqIn | (irqFlag & ~(dec.statWr & wrData[2]));
      errFlag <= engErr   | (errFlag & ~(dec.statWr & wrData[1]));
    end
  end

  // read mux: shift by offset, mask to width
  always_comb begin
    case (sel)
      SEL_CMD:  regVal = DATA_W'({4'b0, cmdDir, 2'b0, cmdStart});
      SEL_STAT: regVal = DATA_W'({5'b0, irqFlag, errFlag, active});
      SEL_BASE: regVal = baseAddr;
      default:  regVal = '0;
    endcase
    shiftedRd = regVal >> (8 * offInt);
    rdData    = '0;
    for (int i = 0; i < NBYTES; i++) begin
      if (i < nBytes) rdData[8*i +: 8] = shiftedRd[8*i +: 8];
    end
  end

endmodule

// File: rtl/bm_ctrl.sv
module bm_ctrl
  import bmregs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  hostDec_t    dec,
  input  logic [7:0]  wrByte,
  input  logic        engXferBusy,
  input  logic        engDone,
  output ctrlStrobe_t strb,
  output logic        startReq,
  output logic        stopReq,
  output logic        cmdStart,
  output logic        cmdDir,
  output logic        active
);

  logic startRise, startFall, stopPend, stopNow;

  always_comb begin
    startRise    = dec.cmdWr & wrByte[0] & ~cmdStart;
    startFall    = dec.cmdWr & ~wrByte[0] & cmdStart;
    stopNow      = (startFall & active & ~engXferBusy)
                 | (stopPend & ~engXferBusy & ~startRise);
    strb.loadPtr = startRise;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmdStart <= 1'b0;
      cmdDir   <= 1'b0;
      active   <= 1'b0;
      stopPend <= 1'b0;
      startReq <= 1'b0;
      stopReq  <= 1'b0;
    end else begin
      if (dec.cmdWr) begin
        cmdStart <= wrByte[0];
        cmdDir   <= wrByte[3];
      end
      startReq <= startRise & ~active;
      stopReq  <= stopNow;

      if (startRise | engDone)                   stopPend <= 1'b0;
      else if (startFall & active & engXferBusy) stopPend <= 1'b1;
      else if (stopNow)                          stopPend <= 1'b0;

      if (startRise & ~active)     active <= 1'b1;
      else if (engDone | stopNow)  active <= 1'b0;
    end
  end

endmodule

// File: rtl/busmaster_dma_regs.sv
module busmaster_dma_regs
  import bmregs_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NBYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(NBYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hostWe,
  input  logic [1:0]        hostSel,
  input  logic [OFF_W-1:0]  hostOff,
  input  logic [1:0]        hostSize,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  input  logic              engXferBusy,
  input  logic              engDone,
  input  logic              engErr,
  input  logic              devIrqIn,
  output logic              irqOut,
  output logic              startReq,
  output logic              stopReq,
  output logic              dirOut,
  output logic              activeOut,
  output logic [DATA_W-1:0] curTablePtr
);

  regSel_e     sel;
  hostDec_t    dec;
  ctrlStrobe_t strb;
  logic        cmdStart, irqFlag;

  always_comb begin
    sel        = regSel_e'(hostSel);
    dec.cmdWr  = hostWe & (sel == SEL_CMD)  & (hostOff == '0);
    dec.statWr = hostWe & (sel == SEL_STAT) & (hostOff == '0);
    dec.baseWr = hostWe & (sel == SEL_BASE);
    irqOut     = devIrqIn;
  end

  bm_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .dec         (dec),
    .wrByte      (hostWrData[7:0]),
    .engXferBusy (engXferBusy),
    .engDone     (engDone),
    .strb        (strb),
    .startReq    (startReq),
    .stopReq     (stopReq),
    .cmdStart    (cmdStart),
    .cmdDir      (dirOut),
    .active      (activeOut)
  );

  bm_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .dec      (dec),
    .strb     (strb),
    .sel      (sel),
    .off      (hostOff),
    .sizeCode (hostSize),
    .wrData   (hostWrData),
    .devIrqIn (devIrqIn),
    .engErr   (engErr),
    .cmdStart (cmdStart),
    .cmdDir   (dirOut),
    .active   (activeOut),
    .rdData   (hostRdData),
    .tablePtr (curTablePtr),
    .irqFlag  (irqFlag)
  );

endmodule

// File: rtl/busmaster_dma_regs_chk.sv
module busmaster_dma_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        hostWe,
  input logic [1:0]  hostSel,
  input logic [1:0]  hostOff,
  input logic [31:0] hostWrData,
  input logic        engXferBusy,
  input logic        engDone,
  input logic        devIrqIn,
  input logic        irqFlag,
  input logic        startReq,
  input logic        stopReq,
  input logic        activeOut,
  input logic [31:0] curTablePtr
);

  // R3: a kick only follows a command write that sets start
  a_r3_kick_cause: assert property (@(posedge clk) disable iff (!rst_n)
    startReq |-> $past(hostWe && hostSel == 2'd0 && hostOff == 2'd0 && hostWrData[0]));

  // R3: a kick comes with the active bit set
  a_r3_kick_active: assert property (@(posedge clk) disable iff (!rst_n)
    startReq |-> activeOut);

  // R4: a stop notice means the engine was idle and the channel is inactive
  a_r4_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stopReq |-> (!activeOut && !$past(engXferBusy)));

  // R4: start and stop never coincide
  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(startReq && stopReq));

  // R5: the table pointer is always word aligned
  a_r5_ptr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    curTablePtr[1:0] == 2'b00);

  // R7: a high device interrupt is latched at the next edge
  a_r7_irq_latch: assert property (@(posedge clk) disable iff (!rst_n)
    devIrqIn |=> irqFlag);

  // R9: completion without a host write clears active
  a_r9_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (engDone && !hostWe) |=> !activeOut);

endmodule

bind busmaster_dma_regs busmaster_dma_regs_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hostWe      (hostWe),
  .hostSel     (hostSel),
  .hostOff     (hostOff),
  .hostWrData  (hostWrData),
  .engXferBusy (engXferBusy),
  .engDone     (engDone),
  .devIrqIn    (devIrqIn),
  .irqFlag     (irqFlag),
  .startReq    (startReq),
  .stopReq     (stopReq),
  .activeOut   (activeOut),
  .curTablePtr (curTablePtr)
);

// File: tb/busmaster_dma_regs_tb.sv
`timescale 1ns/1ps
module busmaster_dma_regs_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hostWe = 1'b0;
  logic [1:0]  hostSel = 2'd0;
  logic [1:0]  hostOff = 2'd0;
  logic [1:0]  hostSize = 2'd0;
  logic [31:0] hostWrData = '0;
  logic [31:0] hostRdData;
  logic        engXferBusy = 1'b0;
  logic        engDone = 1'b0;
  logic        engErr = 1'b0;
  logic        devIrqIn = 1'b0;
  logic        irqOut, startReq, stopReq, dirOut, activeOut;
  logic [31:0] curTablePtr;

  int  nRun = 0;
  int  nFail = 0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  busmaster_dma_regs u_dut (
    .clk(clk), .rst_n(rst_n), .hostWe(hostWe), .hostSel(hostSel),
    .hostOff(hostOff), .hostSize(hostSize), .hostWrData(hostWrData),
    .hostRdData(hostRdData), .engXferBusy(engXferBusy), .engDone(engDone),
    .engErr(engErr), .devIrqIn(devIrqIn), .irqOut(irqOut),
    .startReq(startReq), .stopReq(stopReq), .dirOut(dirOut),
    .activeOut(activeOut), .curTablePtr(curTablePtr)
  );

  // address register vector table: write or read, offset, size code, data, expected
  localparam int NV = 14;
  localparam bit          V_WR  [NV] = '{1,0,0,0,1,0,1,0,1,0,0,1,1,0};
  localparam logic [1:0]  V_OFF [NV] = '{0,0,1,2,1,0,0,0,2,0,3,0,0,0};
  localparam logic [1:0]  V_SZ  [NV] = '{2,2,0,1,0,2,0,0,1,2,0,1,0,2};
  localparam logic [31:0] V_DAT [NV] = '{32'h12345677, 0, 0, 0, 32'h000000AB, 0,
                                         32'h000000FF, 0, 32'h0000BEEF, 0, 0,
                                         32'h00000003, 32'hFFFFFF10, 0};
  localparam logic [31:0] V_EXP [NV] = '{0, 32'h12345674, 32'h56, 32'h1234, 0,
                                         32'h1234AB74, 0, 32'hFC, 0, 32'hBEEFABFC,
                                         32'hBE, 0, 0, 32'hBEEF0010};

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, got, exp);
    end
  endtask

  task automatic hwrite(input logic [1:0] sel, input logic [1:0] off,
                        input logic [1:0] sz, input logic [31:0] data);
    hostWe = 1'b1; hostSel = sel; hostOff = off; hostSize = sz; hostWrData = data;
    @(negedge clk);
    hostWe = 1'b0; hostWrData = '0;
  endtask

  task automatic hread(input logic [1:0] sel, input logic [1:0] off,
                       input logic [1:0] sz, output logic [31:0] data);
    hostWe = 1'b0; hostSel = sel; hostOff = off; hostSize = sz;
    #1 data = hostRdData;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();

    // R10: reset state
    hread(2'd0, 2'd0, 2'd2, rd); check("R10 cmd after reset", rd, 0);
    hread(2'd1, 2'd0, 2'd2, rd); check("R10 status after reset", rd, 0);
    hread(2'd2, 2'd0, 2'd2, rd); check("R10 base after reset", rd, 0);
    check("R10 ptr after reset", curTablePtr, 0);
    check("R10 kick/stop after reset", {startReq, stopReq}, 0);

    // R5 R6: vector table on the base address register
    for (int i = 0; i < NV; i++) begin
      if (V_WR[i]) hwrite(2'd2, V_OFF[i], V_SZ[i], V_DAT[i]);
      else begin
        hread(2'd2, V_OFF[i], V_SZ[i], rd);
        check($sformatf("R5/R6 vector %0d", i), rd, V_EXP[i]);
      end
    end

    // R1: only start and direction bits stored
    hwrite(2'd0, 2'd0, 2'd0, 32'hFE);
    hread(2'd0, 2'd0, 2'd0, rd); check("R1 cmd keeps bit3 only", rd, 32'h08);
    check("R1 dirOut", dirOut, 1);
    check("R1 no kick without start", startReq, 0);
    hread(2'd3, 2'd0, 2'd2, rd); check("R1 unused select reads 0", rd, 0);

    // R3: start rising
    hwrite(2'd0, 2'd0, 2'd0, 32'hFF);
    check("R3 kick pulse", startReq, 1);
    check("R3 ptr reload", curTablePtr, 32'hBEEF0010);
    hread(2'd1, 2'd0, 2'd0, rd); check("R3 active set", rd, 32'h01);
    hread(2'd0, 2'd0, 2'd0, rd); check("R1 cmd readback", rd, 32'h09);
    tick();
    check("R3 kick one cycle", startReq, 0);

    // R2: same start bit, no action
    hwrite(2'd2, 2'd0, 2'd2, 32'h00000100);
    hwrite(2'd0, 2'd0, 2'd0, 32'h01);
    check("R2 no kick", startReq, 0);
    check("R2 no stop", stopReq, 0);
    check("R2 ptr unchanged", curTablePtr, 32'hBEEF0010);
    check("R2 dir updated", dirOut, 0);

    // R8: host cannot clear active
    hwrite(2'd1, 2'd0, 2'd0, 32'h01);
    hread(2'd1, 2'd0, 2'd0, rd); check("R8 active not host writable", rd, 32'h01);

    // R9: completion clears active
    engDone = 1'b1; tick(); engDone = 1'b0;
    hread(2'd1, 2'd0, 2'd0, rd); check("R9 done clears active", rd, 0);

    // R4: deferred stop
    hwrite(2'd0, 2'd0, 2'd0, 32'h00);
    check("R4 no stop when inactive", stopReq, 0);
    hwrite(2'd0, 2'd0, 2'd0, 32'h01);
    check("R3 second kick", startReq, 1);
    check("R3 ptr new base", curTablePtr, 32'h100);
    engXferBusy = 1'b1;
    hwrite(2'd0, 2'd0, 2'd0, 32'h00);
    check("R4 no stop while busy", stopReq, 0);
    repeat (3) tick();
    check("R4 active held while busy", activeOut, 1);
    engXferBusy = 1'b0;
    tick();
    check("R4 stop after drain", stopReq, 1);
    check("R4 active cleared after drain", activeOut, 0);
    tick();
    check("R4 stop one cycle", stopReq, 0);

    // R4: immediate stop when idle
    hwrite(2'd0, 2'd0, 2'd0, 32'h01);
    hwrite(2'd0, 2'd0, 2'd0, 32'h00);
    check("R4 immediate stop", stopReq, 1);
    check("R4 immediate inactive", activeOut, 0);

    // R4 R3: restart cancels a pending stop
    hwrite(2'd0, 2'd0, 2'd0, 32'h01);
    hwrite(2'd2, 2'd0, 2'd2, 32'h00000200);
    engXferBusy = 1'b1;
    hwrite(2'd0, 2'd0, 2'd0, 32'h00);
    hwrite(2'd0, 2'd0, 2'd0, 32'h01);
    check("R3 no kick while active", startReq, 0);
    check("R3 ptr reloaded while active", curTablePtr, 32'h200);
    engXferBusy = 1'b0;
    tick();
    check("R4 cancelled stop keeps active", activeOut, 1);
    check("R4 cancelled stop no pulse", stopReq, 0);
    engDone = 1'b1; tick(); engDone = 1'b0;
    check("R9 done clears active", activeOut, 0);

    // R7: interrupt latching and pass-through
    devIrqIn = 1'b1;
    #1 check("R7 irqOut follows high", irqOut, 1);
    tick();
    hread(2'd1, 2'd0, 2'd0, rd); check("R7 irq bit set", rd, 32'h04);
    devIrqIn = 1'b0;
    #1 check("R7 irqOut follows low", irqOut, 0);
    tick();
    hread(2'd1, 2'd0, 2'd0, rd); check("R7 low keeps irq bit", rd, 32'h04);
    hwrite(2'd1, 2'd0, 2'd0, 32'h04);
    hread(2'd1, 2'd0, 2'd0, rd); check("R8 irq W1C", rd, 0);
    devIrqIn = 1'b1;
    hwrite(2'd1, 2'd0, 2'd0, 32'h04);
    hread(2'd1, 2'd0, 2'd0, rd); check("R8 set wins over clear", rd, 32'h04);
    devIrqIn = 1'b0;
    hwrite(2'd1, 2'd0, 2'd0, 32'h04);

    // R8: error bit
    engErr = 1'b1; tick(); engErr = 1'b0;
    hread(2'd1, 2'd0, 2'd0, rd); check("R8 err set", rd, 32'h02);
    hwrite(2'd1, 2'd0, 2'd0, 32'h04);
    hread(2'd1, 2'd0, 2'd0, rd); check("R8 err kept on 0 write", rd, 32'h02);
    hwrite(2'd1, 2'd0, 2'd0, 32'h02);
    hread(2'd1, 2'd0, 2'd0, rd); check("R8 err W1C", rd, 0);

    // R10: reset in the middle of activity
    hwrite(2'd0, 2'd0, 2'd0, 32'h09);
    devIrqIn = 1'b1; tick(); devIrqIn = 1'b0;
    rst_n = 1'b0; tick(); rst_n = 1'b1;
    hread(2'd0, 2'd0, 2'd2, rd); check("R10 cmd cleared", rd, 0);
    hread(2'd1, 2'd0, 2'd2, rd); check("R10 status cleared", rd, 0);
    hread(2'd2, 2'd0, 2'd2, rd); check("R10 base cleared", rd, 0);
    check("R10 ptr cleared", curTablePtr, 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule